// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block sits beside a pair of transmit and receive FIFOs and turns their fill levels and error events into interrupt status. Two of its five sources are level comparisons against programmable thresholds. One fires when the receive FIFO holds more entries than its threshold. The other fires when the transmit FIFO has drained to its threshold or below. The other three sources are sticky error flags. They record a push into a full transmit FIFO, a push into a full receive FIFO, and a pop from an empty receive FIFO.

Software programs the two thresholds and a source mask through a small write port. It clears the sticky flags through a write-one-to-clear register that has one bit per flag and one bit that clears every flag. The block presents the raw status, the masked status, and a single interrupt line. The FIFO storage and the serial engine are outside this block.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: While reset (`rst_n` low, sampled synchronously) is applied, the raw status, the masked status and `irq` are all zero. The thresholds and the mask reset to zero.
- R2: Raw status bit 4 (receive full) is 1 one clock after `rx_level` exceeds the receive threshold, and 0 one clock after it does not.
- R3: Raw status bit 0 (transmit empty) is 1 one clock after `tx_level` is less than or equal to the transmit threshold, and 0 otherwise. With a threshold of 0 it is 1 only when the level is 0.
- R4: A one-cycle pulse sets a sticky flag, which then holds. `tx_push_full` sets raw bit 1, `rx_push_full` sets raw bit 3, and `rx_pop_empty` sets raw bit 2.
- R5: A write to the clear register clears flags in the cycle after the write. Data bit 3 clears raw bit 1, data bit 2 clears raw bit 3, data bit 1 clears raw bit 2, and data bit 0 clears all three.
- R6: When a clear and a flag's event arrive in the same cycle, the flag ends up set.
- R7: A clear write has no effect on raw bits 4 and 0, which follow only the levels and thresholds.
- R8: The masked status equals raw status AND mask. Each source uses the same bit position in both.
- R9: `irq` is the OR of the masked status bits. With the mask at zero, `irq` stays low whatever the raw status.
- R10: A write with `reg_wr` high takes effect at the clock edge and affects only the register that `reg_sel` selects. The encodings are 0 = transmit threshold, 1 = receive threshold, 2 = mask, and 3 = clear. The data comes from `reg_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_level | input | 6 | Transmit FIFO fill level |
| rx_level | input | 6 | Receive FIFO fill level |
| tx_push_full | input | 1 | Pulse: push into a full transmit FIFO |
| rx_push_full | input | 1 | Pulse: push into a full receive FIFO |
| rx_pop_empty | input | 1 | Pulse: pop from an empty receive FIFO |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 tx threshold, 1 rx threshold, 2 mask, 3 clear) |
| reg_wdata | input | 5 | Register write data |
| raw_stat | output | 5 | Raw interrupt status |
| mask_stat | output | 5 | Masked interrupt status |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle, the assertions check four things. Sticky flags hold unless cleared, an event always wins over a clear, and a clear without an event empties a flag. The level bits stay put while the level and the threshold are unchanged. The masked status never holds a bit the raw status lacks, and `irq` never rises without a raw source. Only the bench scenarios can show the rest: the exact threshold boundaries (equal versus one above), the mapping from clear-register bits to flags, that a clear leaves the level bits alone, and that writes reach only the selected register.

// File: rtl/fic_pkg.sv
// fic_pkg: shared constants for the FIFO threshold interrupt controller.
// Assumes sources share one bit position across raw, mask and masked status.
package fic_pkg;
    localparam int NUM_SRC    = 5;
    localparam int NUM_STICKY = 3;

    // Status bit positions
    localparam int SRC_TX_EMPTY = 0;
    localparam int SRC_TX_OVF   = 1;
    localparam int SRC_RX_UNF   = 2;
    localparam int SRC_RX_OVF   = 3;
    localparam int SRC_RX_FULL  = 4;

    // Clear register bit positions
    localparam int CLR_ALL    = 0;
    localparam int CLR_RX_UNF = 1;
    localparam int CLR_RX_OVF = 2;
    localparam int CLR_TX_OVF = 3;

    typedef enum logic [1:0] {
        SEL_TX_THR = 2'd0,
        SEL_RX_THR = 2'd1,
        SEL_MASK   = 2'd2,
        SEL_CLEAR  = 2'd3
    } reg_sel_e;

    // Sticky slot i -> raw status bit
    function automatic int sticky_raw_bit(input int i);
        case (i)
            0:       return SRC_TX_OVF;
            1:       return SRC_RX_UNF;
            default: return SRC_RX_OVF;
        endcase
    endfunction

    // Sticky slot i -> clear register bit
    function automatic int sticky_clr_bit(input int i);
        case (i)
            0:       return CLR_TX_OVF;
            1:       return CLR_RX_UNF;
            default: return CLR_RX_OVF;
        endcase
    endfunction
endpackage

// File: rtl/fic_thresh.sv
// fic_thresh: holds the two thresholds and registers the level-based sources.
// Assumes LEVEL_W >= THR_W; outputs lag the level inputs by one clock.
module fic_thresh #(
    parameter int LEVEL_W = 6,
    parameter int THR_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_tx_thr,
    input  logic               wr_rx_thr,
    input  logic [THR_W-1:0]   wdata,
    input  logic [LEVEL_W-1:0] tx_level,
    input  logic [LEVEL_W-1:0] rx_level,
    output logic               tx_empty_q,
    output logic               rx_full_q
);
    logic [THR_W-1:0] tx_thr_q;
    logic [THR_W-1:0] rx_thr_q;

    // Threshold registers, written by the select decode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr_q <= '0;
            rx_thr_q <= '0;
        end else begin
            if (wr_tx_thr) tx_thr_q <= wdata;
            if (wr_rx_thr) rx_thr_q <= wdata;
        end
    end

    // Level comparisons, registered once per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_empty_q <= 1'b0;
            rx_full_q  <= 1'b0;
        end else begin
            tx_empty_q <= (tx_level <= LEVEL_W'(tx_thr_q));
            rx_full_q  <= (rx_level >  LEVEL_W'(rx_thr_q));
        end
    end

    // R2: receive-full is steady while level and threshold are steady
    a_r2_rx_full_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(rx_level) && $stable(rx_thr_q)) |=> $stable(rx_full_q));

    // R3: transmit-empty is steady while level and threshold are steady
    a_r3_tx_empty_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(tx_level) && $stable(tx_thr_q)) |=> $stable(tx_empty_q));
endmodule

// File: rtl/fic_sticky.sv
// fic_sticky: a bank of sticky event flags with per-flag clear.
// Assumes event and clear are single-cycle qualified strobes; event beats clear.
module fic_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag_q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Set on event, drop on clear, otherwise hold
        always_ff @(posedge clk) begin
            if (!rst_n)      flag_q[i] <= 1'b0;
            else if (ev[i])  flag_q[i] <= 1'b1;
            else if (clr[i]) flag_q[i] <= 1'b0;
        end

        // R4: a flag holds without a clear
        a_r4_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr[i]) |=> flag_q[i]);

        // R6: an event sets the flag even with a clear in the same cycle
        a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
            ev[i] |=> flag_q[i]);

        // R5: a clear without an event empties the flag
        a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !ev[i]) |=> !flag_q[i]);
    end
endmodule

// File: rtl/fic_combine.sv
// fic_combine: holds the source mask, forms masked status and the interrupt.
// Assumes raw status arrives registered; outputs are combinational from state.
module fic_combine #(
    parameter int NUM_SRC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_mask,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [NUM_SRC-1:0] raw,
    output logic [NUM_SRC-1:0] masked,
    output logic               irq
);
    logic [NUM_SRC-1:0] mask_q;

    // Mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wdata;
    end

    // Gate raw sources and merge into one line
    always_comb begin
        masked = raw & mask_q;
        irq    = |masked;
    end

    // R8: masked status never carries a bit absent from raw status
    a_r8_masked_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (masked & ~raw) == '0);

    // R9: no interrupt with mask cleared
    a_r9_mask_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);
endmodule

// File: rtl/fifo_irq_ctrl.sv
// fifo_irq_ctrl: FIFO level/error interrupt controller top.
// Decodes register writes, assembles raw status from threshold and sticky
// sources, and drives masked status and one interrupt line.
// Assumes event inputs are single-cycle pulses in the clk domain.
module fifo_irq_ctrl
    import fic_pkg::*;
#(
    parameter int LEVEL_W = 6,
    parameter int THR_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LEVEL_W-1:0] tx_level,
    input  logic [LEVEL_W-1:0] rx_level,
    input  logic               tx_push_full,
    input  logic               rx_push_full,
    input  logic               rx_pop_empty,
    input  logic               reg_wr,
    input  logic [1:0]         reg_sel,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] raw_stat,
    output logic [NUM_SRC-1:0] mask_stat,
    output logic               irq
);
    localparam int CLR_W = NUM_STICKY + 1;

    reg_sel_e            sel;
    logic                wr_tx_thr, wr_rx_thr, wr_mask, wr_clear;
    logic [NUM_STICKY-1:0] st_ev, st_clr, st_flag;
    logic [CLR_W-1:0]    clr_bits;
    logic                tx_empty_q, rx_full_q;

    // Register select decode (R10)
    always_comb begin
        sel       = reg_sel_e'(reg_sel);
        wr_tx_thr = reg_wr && (sel == SEL_TX_THR);
        wr_rx_thr = reg_wr && (sel == SEL_RX_THR);
        wr_mask   = reg_wr && (sel == SEL_MASK);
        wr_clear  = reg_wr && (sel == SEL_CLEAR);
        clr_bits  = reg_wdata[CLR_W-1:0];
    end

    // Event and clear vectors per sticky slot
    always_comb begin
        st_ev[0] = tx_push_full;
        st_ev[1] = rx_pop_empty;
        st_ev[2] = rx_push_full;
        for (int i = 0; i < NUM_STICKY; i++) begin
            st_clr[i] = wr_clear && (clr_bits[CLR_ALL] || clr_bits[sticky_clr_bit(i)]);
        end
    end

    // Raw status assembly
    always_comb begin
        raw_stat               = '0;
        raw_stat[SRC_TX_EMPTY] = tx_empty_q;
        raw_stat[SRC_RX_FULL]  = rx_full_q;
        for (int i = 0; i < NUM_STICKY; i++) begin
            raw_stat[sticky_raw_bit(i)] = st_flag[i];
        end
    end

    fic_thresh #(.LEVEL_W(LEVEL_W), .THR_W(THR_W)) u_thresh (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_tx_thr  (wr_tx_thr),
        .wr_rx_thr  (wr_rx_thr),
        .wdata      (reg_wdata[THR_W-1:0]),
        .tx_level   (tx_level),
        .rx_level   (rx_level),
        .tx_empty_q (tx_empty_q),
        .rx_full_q  (rx_full_q)
    );

    fic_sticky #(.N(NUM_STICKY)) u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (st_ev),
        .clr    (st_clr),
        .flag_q (st_flag)
    );

    fic_combine #(.NUM_SRC(NUM_SRC)) u_combine (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_mask(wr_mask),
        .wdata  (reg_wdata),
        .raw    (raw_stat),
        .masked (mask_stat),
        .irq    (irq)
    );

    // R9: the interrupt only rises with some raw source active
    a_r9_irq_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_stat != '0));

    // R7: a clear write never drops an active receive-full source by itself
    a_r7_clear_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clear && rx_full_q && $stable(rx_level) && $past(rst_n) && !wr_rx_thr)
            |=> rx_full_q);
endmodule

// File: tb/sim_fifo_irq_ctrl.sv
`timescale 1ns/1ps
module sim_fifo_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] tx_level, rx_level;
    logic       tx_push_full, rx_push_full, rx_pop_empty;
    logic       reg_wr;
    logic [1:0] reg_sel;
    logic [4:0] reg_wdata;
    logic [4:0] raw_stat, mask_stat;
    logic       irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    fifo_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_push_full(tx_push_full), .rx_push_full(rx_push_full),
        .rx_pop_empty(rx_pop_empty),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .raw_stat(raw_stat), .mask_stat(mask_stat), .irq(irq)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [4:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(2);
        chk("R1 raw in reset", raw_stat, 0);
        chk("R1 masked in reset", mask_stat, 0);
        chk("R1 irq in reset", irq, 0);
        rst_n = 1'b1;
        tick(1);
        chk("R3 empty after reset", raw_stat, 5'b00001);
        chk("R9 irq low with zero mask", irq, 0);
    endtask

    task automatic t_rx_thresh();
        wr(2'd1, 5'd3);
        rx_level = 6'd3; tick(1);
        chk("R2 level equal thr", raw_stat[4], 0);
        rx_level = 6'd4; tick(1);
        chk("R2 level above thr", raw_stat[4], 1);
        wr(2'd0, 5'd0);  // R10: tx threshold write leaves rx threshold alone
        rx_level = 6'd4; tick(1);
        chk("R10 rx thr untouched", raw_stat[4], 1);
        wr(2'd1, 5'd0);
        rx_level = 6'd0; tick(1);
        chk("R2 thr0 level0", raw_stat[4], 0);
        rx_level = 6'd1; tick(1);
        chk("R2 thr0 level1", raw_stat[4], 1);
        rx_level = 6'd0; tick(1);
    endtask

    task automatic t_tx_thresh();
        wr(2'd0, 5'd0);
        tx_level = 6'd0; tick(1);
        chk("R3 thr0 level0", raw_stat[0], 1);
        tx_level = 6'd1; tick(1);
        chk("R3 thr0 level1", raw_stat[0], 0);
        wr(2'd0, 5'd16);
        tx_level = 6'd16; tick(1);
        chk("R3 level equal thr", raw_stat[0], 1);
        tx_level = 6'd32; tick(1);
        chk("R3 level full", raw_stat[0], 0);
        tx_level = 6'd17; tick(1);
        chk("R3 level above thr", raw_stat[0], 0);
    endtask

    task automatic t_sticky();
        tx_push_full = 1'b1; tick(1); tx_push_full = 1'b0;
        chk("R4 tx overflow set", raw_stat, 5'b00010);
        tick(3);
        chk("R4 tx overflow holds", raw_stat, 5'b00010);
        rx_push_full = 1'b1; tick(1); rx_push_full = 1'b0;
        chk("R4 rx overflow set", raw_stat, 5'b01010);
        rx_pop_empty = 1'b1; tick(1); rx_pop_empty = 1'b0;
        chk("R4 rx underflow set", raw_stat, 5'b01110);
    endtask

    task automatic t_clear();
        wr(2'd3, 5'b01000);
        chk("R5 clear tx overflow", raw_stat, 5'b01100);
        wr(2'd3, 5'b00100);
        chk("R5 clear rx overflow", raw_stat, 5'b00100);
        wr(2'd3, 5'b00010);
        chk("R5 clear rx underflow", raw_stat, 5'b00000);
        tx_push_full = 1'b1; rx_push_full = 1'b1; rx_pop_empty = 1'b1;
        tick(1);
        tx_push_full = 1'b0; rx_push_full = 1'b0; rx_pop_empty = 1'b0;
        chk("R4 all flags set", raw_stat, 5'b01110);
        wr(2'd3, 5'b00001);
        chk("R5 clear all", raw_stat, 5'b00000);
    endtask

    task automatic t_event_wins();
        rx_pop_empty = 1'b1; tick(1); rx_pop_empty = 1'b0;
        rx_pop_empty = 1'b1;
        wr(2'd3, 5'b00010);
        rx_pop_empty = 1'b0;
        chk("R6 underflow event beats clear", raw_stat, 5'b00100);
        tx_push_full = 1'b1;
        wr(2'd3, 5'b00001);
        tx_push_full = 1'b0;
        chk("R6 event beats clear-all", raw_stat, 5'b00010);
        wr(2'd3, 5'b00001);
        chk("R5 clear-all after race", raw_stat, 5'b00000);
    endtask

    task automatic t_clear_levels();
        rx_level = 6'd5; tx_level = 6'd3; tick(1);
        chk("R2 R3 both level sources", raw_stat, 5'b10001);
        wr(2'd3, 5'b11111);
        chk("R7 clear leaves level bits", raw_stat, 5'b10001);
        tick(1);
        chk("R7 level bits still set", raw_stat, 5'b10001);
    endtask

    task automatic t_mask();
        tx_push_full = 1'b1; tick(1); tx_push_full = 1'b0;
        chk("R4 raw before mask", raw_stat, 5'b10011);
        wr(2'd2, 5'b00000);
        chk("R9 mask zero irq", irq, 0);
        chk("R8 mask zero masked", mask_stat, 0);
        wr(2'd2, 5'b00010);
        chk("R8 single bit masked", mask_stat, 5'b00010);
        chk("R9 single bit irq", irq, 1);
        wr(2'd2, 5'b01100);
        chk("R8 disjoint mask", mask_stat, 0);
        chk("R9 disjoint mask irq", irq, 0);
        wr(2'd2, 5'b11111);
        chk("R8 full mask", mask_stat, 5'b10011);
        wr(2'd3, 5'b00001);
        chk("R8 after clear-all", mask_stat, 5'b10001);
        chk("R9 level sources keep irq", irq, 1);
        rx_level = 6'd0; tx_level = 6'd20; tick(1);
        chk("R9 all sources idle", irq, 0);
    endtask

    initial begin
        rst_n = 1'b0; tx_level = '0; rx_level = '0;
        tx_push_full = 1'b0; rx_push_full = 1'b0; rx_pop_empty = 1'b0;
        reg_wr = 1'b0; reg_sel = '0; reg_wdata = '0;
        @(negedge clk);
        t_reset();
        t_rx_thresh();
        t_tx_thresh();
        t_sticky();
        t_clear();
        t_event_wins();
        t_clear_levels();
        t_mask();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule